// File: doc/BRIEF.md
# Indirect CSR Write Bridge

This block gives a host processor write access to a wide internal register space through a few host-visible words. The host side is a plain synchronous register port. It carries a word address, write data and a write strobe, and it returns combinational readback of the command and data words. On the fabric side the block drives one register write at a time: a 16-bit target address, 32-bit data and four byte enables, offered on a valid/ready handshake.

A fabric write can be launched in three ways:
- **Command launch.** The host loads the data word, then writes the command word with the busy flag set.
- **Stepped data launch.** The host arms stepping in the command word. Each later data write then launches a transfer to the current address. The address moves by one when that transfer completes.
- **Window launch.** The host writes into a 64-word window. The block builds the command itself: a translated address and all byte enables on.

The host polls the busy flag to learn when a transfer has finished. A launch attempt made while busy is dropped, and a sticky error flag records it.

Top module: `csr_window_bridge`

## Requirements
- R1: After reset, `fab_valid` is 0, and the command word (host word 0) and data word (host word 1) both read as 0.
- R2: A command-word write while idle stores these fields: address at bits 15:0, byte enables at 19:16, step-down at 28, step-up at 29 and read flag at 30. Readback returns the fields at the same positions, with busy at bit 31 and error at bit 27. Bits 26:20 read as 0.
- R3: A command write while idle launches a fabric write exactly when bit 31 = 1 and bits 30, 29 and 28 = 0. The launch uses the written address and byte enables together with the stored data word. With bit 31 = 1 and bit 30 = 1, there is no launch.
- R4: `fab_valid` rises on the cycle after the launch write. While `fab_ready` is low, `fab_valid`, `fab_addr`, `fab_data` and `fab_be` hold steady. On the cycle after a cycle with `fab_valid` and `fab_ready` both high, `fab_valid` and command bit 31 read 0.
- R5: A command written with bit 29 or bit 28 set launches nothing, even if bit 31 is set. After that, each idle data-word write launches a fabric write to the current address with the stored byte enables.
- R6: When a stepped transfer completes, the address moves by +1 if bit 29 is set, or by −1 if only bit 28 is set. The step-up wins when both bits are set. The address wraps modulo 2^16.
- R7: An idle host write to word 64+n (n = 0..63) launches a write to fabric address 0x0200+n with data equal to the written value and byte enables 0xF. It also clears the read flag and updates the command address field.
- R8: While busy, the following writes are ignored and set the error flag (bit 27): a command write with bit 31 set, a data write in step mode, and a window write. None of them changes the fabric outputs.
- R9: A command write with bit 27 = 1 clears the error flag. Writing 0 to bit 27 leaves the flag unchanged.
- R10: A data write while idle with stepping off only loads the data word and launches nothing. A data write while busy with stepping off is ignored and does not set the error flag.
- R11: Host words other than 0, 1 and 64..127 read as 0. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_rdata | output | 32 | Readback of the addressed word (combinational) |
| fab_valid | output | 1 | Fabric write request, held until accepted |
| fab_ready | input | 1 | Fabric acceptance pulse |
| fab_addr | output | 16 | Fabric target address |
| fab_data | output | 32 | Fabric write data |
| fab_be | output | 4 | Fabric byte enables |

The fabric interface follows valid/ready rules. Once `fab_valid` is raised, it and the payload stay unchanged until a cycle in which `fab_ready` is high. Back-pressure from the fabric simply stretches the busy period, and no second request is ever queued behind the first.

## Verification
The command launch is tried with a table of addresses that span both ends of the range and with several byte-enable shapes. Each entry is held against several cycles of withheld acceptance, which separates a payload that is truly held from one that only looks correct at the launch edge. Stepped launches are run upward, downward, with both step bits set, and across both wrap points, which shows whether the step direction, the priority rule and the 16-bit wrap are each right. Window writes to the first and last slot show whether the translation offset is correct. Collision writes of each kind, issued mid-transfer, show whether a dropped request really leaves the payload alone and whether it sets the sticky flag.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int unsigned CMD_BUSY_BIT = 31;
  localparam int unsigned CMD_READ_BIT = 30;
  localparam int unsigned CMD_UP_BIT   = 29;
  localparam int unsigned CMD_DOWN_BIT = 28;
  localparam int unsigned CMD_ERR_BIT  = 27;
  localparam int unsigned CMD_BE_LSB   = 16;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_CMD,
    OP_DATA,
    OP_WIN
  } host_op_e;
endpackage

// File: rtl/cwb_decode.sv
module cwb_decode
  import cwb_pkg::*;
#(
  parameter int HOST_AW   = 8,
  parameter int FAB_AW    = 16,
  parameter int CMD_WORD  = 0,
  parameter int DATA_WORD = 1,
  parameter int WIN_BASE  = 64,
  parameter int WIN_SLOTS = 64,
  parameter int FAB_BASE  = 'h0200
) (
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_we,
  output host_op_e           op,
  output logic               sel_cmd,
  output logic               sel_data,
  output logic [FAB_AW-1:0]  win_addr
);
  localparam int SLOT_W = (WIN_SLOTS > 1) ? $clog2(WIN_SLOTS) : 1;

  logic [31:0] addr_w;
  logic        in_win;

  assign addr_w   = 32'(host_addr);
  assign sel_cmd  = (addr_w == 32'(CMD_WORD));
  assign sel_data = (addr_w == 32'(DATA_WORD));

  generate
    if (WIN_SLOTS > 0) begin : g_win
      logic [SLOT_W-1:0] slot;
      assign in_win   = (addr_w >= 32'(WIN_BASE)) &&
                        (addr_w <  32'(WIN_BASE + WIN_SLOTS));
      assign slot     = SLOT_W'(addr_w - 32'(WIN_BASE));
      assign win_addr = FAB_AW'(FAB_BASE) + FAB_AW'(slot);
    end else begin : g_nowin
      assign in_win   = 1'b0;
      assign win_addr = '0;
    end
  endgenerate

  always_comb begin
    op = OP_NONE;
    if (host_we) begin
      if (sel_cmd)       op = OP_CMD;
      else if (sel_data) op = OP_DATA;
      else if (in_win)   op = OP_WIN;
    end
  end
endmodule

// File: rtl/cwb_step.sv
module cwb_step #(
  parameter int FAB_AW       = 16,
  parameter bit UP_PRIORITY  = 1'b1
) (
  input  logic [FAB_AW-1:0] cur,
  input  logic              up,
  input  logic              down,
  output logic              active,
  output logic [FAB_AW-1:0] nxt
);
  logic go_up;

  generate
    if (UP_PRIORITY) begin : g_up_wins
      assign go_up = up;
    end else begin : g_down_wins
      assign go_up = up && !down;
    end
  endgenerate

  assign active = up || down;
  assign nxt    = go_up ? cur + FAB_AW'(1) : cur - FAB_AW'(1);
endmodule

// File: rtl/cwb_core.sv
module cwb_core
  import cwb_pkg::*;
#(
  parameter int FAB_AW = 16,
  parameter int DW     = 32,
  parameter int BE_W   = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  host_op_e          op,
  input  logic [DW-1:0]     wdata,
  input  logic [FAB_AW-1:0] win_addr,
  input  logic              fab_ready,
  input  logic              step_active,
  input  logic [FAB_AW-1:0] step_addr,
  output logic              busy,
  output logic              err,
  output logic              up,
  output logic              down,
  output logic [FAB_AW-1:0] addr,
  output logic [BE_W-1:0]   be,
  output logic [DW-1:0]     data,
  output logic [31:0]       cmd_word
);
  logic rd_flag;
  logic cmd_launch;

  assign cmd_launch = wdata[CMD_BUSY_BIT] && !wdata[CMD_READ_BIT] &&
                      !wdata[CMD_UP_BIT] && !wdata[CMD_DOWN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      err     <= 1'b0;
      up      <= 1'b0;
      down    <= 1'b0;
      rd_flag <= 1'b0;
      addr    <= '0;
      be      <= '0;
      data    <= '0;
    end else begin
      if (busy && fab_ready) begin
        busy <= 1'b0;
        if (step_active) addr <= step_addr;
      end
      unique case (op)
        OP_CMD: begin
          if (wdata[CMD_ERR_BIT]) err <= 1'b0;
          if (busy) begin
            if (wdata[CMD_BUSY_BIT]) err <= 1'b1;
          end else begin
            rd_flag <= wdata[CMD_READ_BIT];
            up      <= wdata[CMD_UP_BIT];
            down    <= wdata[CMD_DOWN_BIT];
            be      <= wdata[CMD_BE_LSB +: BE_W];
            addr    <= wdata[FAB_AW-1:0];
            busy    <= cmd_launch;
          end
        end
        OP_DATA: begin
          if (busy) begin
            if (up || down) err <= 1'b1;
          end else begin
            data <= wdata;
            if (up || down) busy <= 1'b1;
          end
        end
        OP_WIN: begin
          if (busy) begin
            err <= 1'b1;
          end else begin
            addr    <= win_addr;
            be      <= '1;
            rd_flag <= 1'b0;
            data    <= wdata;
            busy    <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cmd_word                          = '0;
    cmd_word[FAB_AW-1:0]              = addr;
    cmd_word[CMD_BE_LSB +: BE_W]      = be;
    cmd_word[CMD_ERR_BIT]             = err;
    cmd_word[CMD_DOWN_BIT]            = down;
    cmd_word[CMD_UP_BIT]              = up;
    cmd_word[CMD_READ_BIT]            = rd_flag;
    cmd_word[CMD_BUSY_BIT]            = busy;
  end
endmodule

// File: rtl/csr_window_bridge.sv
module csr_window_bridge
  import cwb_pkg::*;
#(
  parameter int HOST_AW   = 8,
  parameter int FAB_AW    = 16,
  parameter int DW        = 32,
  parameter int WIN_BASE  = 64,
  parameter int WIN_SLOTS = 64,
  parameter int FAB_BASE  = 'h0200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DW-1:0]      host_wdata,
  input  logic               host_we,
  output logic [DW-1:0]      host_rdata,
  output logic               fab_valid,
  input  logic               fab_ready,
  output logic [FAB_AW-1:0]  fab_addr,
  output logic [DW-1:0]      fab_data,
  output logic [DW/8-1:0]    fab_be
);
  localparam int BE_W = DW / 8;

  host_op_e          op;
  logic              sel_cmd;
  logic              sel_data;
  logic [FAB_AW-1:0] win_addr;
  logic              step_active;
  logic [FAB_AW-1:0] step_addr;
  logic              busy;
  logic              err_flag;
  logic              up_flag;
  logic              down_flag;
  logic [FAB_AW-1:0] cur_addr;
  logic [BE_W-1:0]   cur_be;
  logic [DW-1:0]     cur_data;
  logic [31:0]       cmd_word;

  cwb_decode #(
    .HOST_AW(HOST_AW), .FAB_AW(FAB_AW), .CMD_WORD(0), .DATA_WORD(1),
    .WIN_BASE(WIN_BASE), .WIN_SLOTS(WIN_SLOTS), .FAB_BASE(FAB_BASE)
  ) u_decode (
    .host_addr(host_addr), .host_we(host_we), .op(op),
    .sel_cmd(sel_cmd), .sel_data(sel_data), .win_addr(win_addr)
  );

  cwb_step #(.FAB_AW(FAB_AW), .UP_PRIORITY(1'b1)) u_step (
    .cur(cur_addr), .up(up_flag), .down(down_flag),
    .active(step_active), .nxt(step_addr)
  );

  cwb_core #(.FAB_AW(FAB_AW), .DW(DW), .BE_W(BE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .op(op), .wdata(host_wdata),
    .win_addr(win_addr), .fab_ready(fab_ready),
    .step_active(step_active), .step_addr(step_addr),
    .busy(busy), .err(err_flag), .up(up_flag), .down(down_flag),
    .addr(cur_addr), .be(cur_be), .data(cur_data), .cmd_word(cmd_word)
  );

  assign fab_valid = busy;
  assign fab_addr  = cur_addr;
  assign fab_data  = cur_data;
  assign fab_be    = cur_be;

  always_comb begin
    host_rdata = '0;
    if (sel_cmd)       host_rdata = DW'(cmd_word);
    else if (sel_data) host_rdata = cur_data;
  end
endmodule

// File: rtl/cwb_checker.sv
module cwb_checker #(
  parameter int HOST_AW   = 8,
  parameter int FAB_AW    = 16,
  parameter int DW        = 32,
  parameter int WIN_BASE  = 64,
  parameter int WIN_SLOTS = 64,
  parameter int FAB_BASE  = 'h0200
) (
  input logic               clk,
  input logic               rst_n,
  input logic [HOST_AW-1:0] host_addr,
  input logic [DW-1:0]      host_wdata,
  input logic               host_we,
  input logic               fab_valid,
  input logic               fab_ready,
  input logic [FAB_AW-1:0]  fab_addr,
  input logic [DW-1:0]      fab_data,
  input logic [DW/8-1:0]    fab_be,
  input logic               err_flag,
  input logic               up_flag,
  input logic               down_flag
);
  logic        win_hit;
  logic [31:0] ha;
  assign ha      = 32'(host_addr);
  assign win_hit = host_we && (ha >= 32'(WIN_BASE)) && (ha < 32'(WIN_BASE + WIN_SLOTS));

  AST_CMD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!fab_valid && host_we && ha == 32'd0 && host_wdata[31:28] == 4'b1000)
    |=> (fab_valid && fab_addr == $past(host_wdata[FAB_AW-1:0])
         && fab_be == $past(host_wdata[19:16]))); // R3

  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_valid && !fab_ready)
    |=> (fab_valid && $stable(fab_addr) && $stable(fab_data) && $stable(fab_be))); // R4

  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_valid && fab_ready) |=> !fab_valid); // R4

  AST_STEP_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fab_valid && host_we && ha == 32'd0 && (host_wdata[29] || host_wdata[28]))
    |=> !fab_valid); // R5

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_valid && fab_ready && up_flag)
    |=> (fab_addr == $past(fab_addr) + FAB_AW'(1))); // R6

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_valid && fab_ready && !up_flag && down_flag)
    |=> (fab_addr == $past(fab_addr) - FAB_AW'(1))); // R6

  AST_WIN_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!fab_valid && win_hit)
    |=> (fab_valid && fab_be == '1 && fab_data == $past(host_wdata)
         && fab_addr == FAB_AW'(FAB_BASE) + FAB_AW'($past(ha) - 32'(WIN_BASE)))); // R7

  AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_valid && win_hit) |=> err_flag); // R8
endmodule

bind csr_window_bridge cwb_checker #(
  .HOST_AW(HOST_AW), .FAB_AW(FAB_AW), .DW(DW),
  .WIN_BASE(WIN_BASE), .WIN_SLOTS(WIN_SLOTS), .FAB_BASE(FAB_BASE)
) u_cwb_checker (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_we(host_we), .fab_valid(fab_valid), .fab_ready(fab_ready),
  .fab_addr(fab_addr), .fab_data(fab_data), .fab_be(fab_be),
  .err_flag(err_flag), .up_flag(up_flag), .down_flag(down_flag)
);

// File: tb/test_csr_window_bridge.sv
`timescale 1ns/1ps
module test_csr_window_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_we = 1'b0;
  logic [31:0] host_rdata;
  logic        fab_valid;
  logic        fab_ready = 1'b0;
  logic [15:0] fab_addr;
  logic [31:0] fab_data;
  logic [3:0]  fab_be;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  csr_window_bridge i_csr_window_bridge (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_rdata(host_rdata), .fab_valid(fab_valid),
    .fab_ready(fab_ready), .fab_addr(fab_addr), .fab_data(fab_data), .fab_be(fab_be)
  );

  // {fab address, byte enables, data}
  localparam logic [51:0] VEC [4] = '{
    {16'h0001, 4'hF, 32'h1234_5678},
    {16'hFFFF, 4'h1, 32'h0000_00FF},
    {16'h8000, 4'h6, 32'hCAFE_F00D},
    {16'h0000, 4'h8, 32'h8000_0001}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic ack();
    @(negedge clk);
    fab_ready = 1'b1;
    @(negedge clk);
    fab_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 valid", {31'b0, fab_valid}, 32'd0);
    rd(8'd0, r); check("R1 cmd", r, 32'd0);
    rd(8'd1, r); check("R1 data", r, 32'd0);

    // R3 R4 table of command launches
    for (int v = 0; v < 4; v++) begin
      logic [15:0] a; logic [3:0] b; logic [31:0] d;
      {a, b, d} = VEC[v];
      wr(8'd1, d);
      check("R10 no launch on data", {31'b0, fab_valid}, 32'd0);
      wr(8'd0, 32'h8000_0000 | (32'(b) << 16) | 32'(a));
      check("R3 valid", {31'b0, fab_valid}, 32'd1);
      check("R3 addr", 32'(fab_addr), 32'(a));
      check("R3 be", 32'(fab_be), 32'(b));
      check("R3 data", fab_data, d);
      idle(3);
      check("R4 held valid", {31'b0, fab_valid}, 32'd1);
      check("R4 held addr", 32'(fab_addr), 32'(a));
      check("R4 held data", fab_data, d);
      ack();
      check("R4 done valid", {31'b0, fab_valid}, 32'd0);
      rd(8'd0, r); check("R4 busy clear", {31'b0, r[31]}, 32'd0);
    end

    // R2 field storage and zero bits
    wr(8'd0, 32'h37F5_1234);
    rd(8'd0, r); check("R2 readback", r, 32'h3005_1234);
    check("R2 no launch", {31'b0, fab_valid}, 32'd0);
    wr(8'd0, 32'hC00F_0010);
    rd(8'd0, r); check("R3 read flag no launch", r, 32'h400F_0010);
    check("R3 read flag valid", {31'b0, fab_valid}, 32'd0);

    // R5 R6 step up with wrap
    wr(8'd0, 32'hA00F_00FE);
    check("R5 armed no launch", {31'b0, fab_valid}, 32'd0);
    wr(8'd1, 32'hAAAA_0001);
    check("R5 data launch", {31'b0, fab_valid}, 32'd1);
    check("R5 addr", 32'(fab_addr), 32'h00FE);
    ack();
    rd(8'd0, r); check("R6 up step", r, 32'h200F_00FF);
    wr(8'd1, 32'hAAAA_0002);
    check("R5 second addr", 32'(fab_addr), 32'h00FF);
    check("R5 second data", fab_data, 32'hAAAA_0002);
    ack();
    rd(8'd0, r); check("R6 up carry", r, 32'h200F_0100);
    wr(8'd0, 32'h2003_FFFF);
    wr(8'd1, 32'h0000_0003);
    check("R5 stored be", 32'(fab_be), 32'h3);
    ack();
    rd(8'd0, r); check("R6 up wrap", r, 32'h2003_0000);
    wr(8'd0, 32'h100F_0000);
    wr(8'd1, 32'h0000_0004);
    ack();
    rd(8'd0, r); check("R6 down wrap", r, 32'h100F_FFFF);
    wr(8'd0, 32'h300F_0010);
    wr(8'd1, 32'h0000_0005);
    ack();
    rd(8'd0, r); check("R6 up wins", r, 32'h300F_0011);

    // R8 collisions while busy (step mode active)
    wr(8'd1, 32'h0000_0006);
    check("R8 busy", {31'b0, fab_valid}, 32'd1);
    wr(8'd1, 32'h5555_5555);
    check("R8 data ignored", fab_data, 32'h0000_0006);
    rd(8'd0, r); check("R8 err set", {31'b0, r[27]}, 32'd1);
    wr(8'd0, 32'h0000_0000);
    wr(8'd70, 32'h7777_7777);
    wr(8'd0, 32'h800F_1234);
    check("R8 addr kept", 32'(fab_addr), 32'h0011);
    check("R8 data kept", fab_data, 32'h0000_0006);
    check("R8 be kept", 32'(fab_be), 32'hF);
    ack();
    rd(8'd0, r); check("R8 fields kept", r, 32'h380F_0012);

    // R9 error clear rules
    wr(8'd0, 32'h000F_0000);
    rd(8'd0, r); check("R9 zero keeps err", r, 32'h080F_0000);
    wr(8'd0, 32'h0800_0000);
    rd(8'd0, r); check("R9 w1c", r, 32'h0000_0000);

    // R10 plain data write while busy: ignored, no error
    wr(8'd0, 32'h800F_0040);
    wr(8'd1, 32'h9999_9999);
    check("R10 busy data ignored", fab_data, 32'h0000_0006);
    ack();
    rd(8'd0, r); check("R10 no err", {31'b0, r[27]}, 32'd0);

    // R7 direct window, first and last slot
    wr(8'd0, 32'h4000_0000);
    wr(8'd69, 32'hDEAD_BEEF);
    check("R7 valid", {31'b0, fab_valid}, 32'd1);
    check("R7 addr", 32'(fab_addr), 32'h0205);
    check("R7 be", 32'(fab_be), 32'hF);
    check("R7 data", fab_data, 32'hDEAD_BEEF);
    rd(8'd0, r); check("R7 cmd", r, 32'h800F_0205);
    rd(8'd1, r); check("R7 data word", r, 32'hDEAD_BEEF);
    ack();
    wr(8'd127, 32'h0BAD_F00D);
    check("R7 last slot", 32'(fab_addr), 32'h023F);
    ack();
    wr(8'd64, 32'h0000_0001);
    check("R7 first slot", 32'(fab_addr), 32'h0200);
    ack();

    // R11 unmapped words
    wr(8'd2, 32'hFFFF_FFFF);
    rd(8'd2, r); check("R11 read zero", r, 32'd0);
    rd(8'd0, r); check("R11 cmd kept", r, 32'h000F_0200);
    rd(8'd1, r); check("R11 data kept", r, 32'h0000_0001);
    wr(8'd128, 32'hFFFF_FFFF);
    check("R11 no launch", {31'b0, fab_valid}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule